// File: doc/BRIEF.md
# Hypervisor Trap Entry Controller

This block moves a small 8-bit CPU core between user mode and a privileged hypervisor mode. User code enters the hypervisor by storing any byte to one of 64 consecutive IO addresses, the trap window. The address that was written picks an entry point in a jump table inside the hypervisor. The byte that was stored has no effect. In the same clock edge that accepts the trap write, the block captures the CPU's architectural state into a bank of shadow bytes. It sets the hypervisor flag, and for one cycle it pulses requests that load the program counter with the entry vector and load a fixed hypervisor memory mapping. The accumulator and the X, Y and Z registers keep their live values, so the hypervisor can use its arguments at once.

While it runs, the hypervisor can read and rewrite the shadow bytes through a second IO window, for example to set the saved carry flag as a success code. It leaves by writing the last address of the trap window. On that edge the block clears the hypervisor flag and, for one cycle, pulses a restore of every saved register, the saved program counter and the saved memory mapping. The restored values include any changes the hypervisor made. Instruction execution, memory arbitration and the hypervisor software belong to the CPU around the block.

Top module: `hyp_trap_ctrl`

## Requirements
- R1: In user mode, a write to any address from 0xD640 to 0xD67F sets `hvMode` on the next clock edge. On that edge `pcLoad` rises with `pcLoadValue` = 0x8000 + 4 × (address − 0xD640), so 0xD640 enters at 0x8000 and 0xD67F enters at 0x80FC.
- R2: The data byte of a trap write has no effect on the entry vector or on any shadow byte.
- R3: On trap entry the shadow bank captures the live state. Reads in hypervisor mode return the captured bytes at these addresses: 0xD600 A, 0xD601 X, 0xD602 Y, 0xD603 Z, 0xD604 flags, 0xD605/0xD606 stack pointer low/high, 0xD607 base page, 0xD608/0xD609 PC low/high, 0xD60A–0xD60D memory map bytes 0 (least significant) to 3.
- R4: On trap entry `mapLoad` pulses with `mapLoadValue` equal to the fixed hypervisor mapping 0x0080_0000, and `regsLoad` stays low.
- R5: In hypervisor mode, a write to 0xD67F clears `hvMode` on the next edge. On that edge `pcLoad`, `mapLoad` and `regsLoad` pulse together and carry the saved PC, the saved map and the saved A, X, Y, Z, flags, stack pointer and base page on the restore outputs.
- R6: In hypervisor mode, writes to 0xD600–0xD60D replace the addressed shadow byte, and the next exit restores the replaced value.
- R7: In hypervisor mode, writes to 0xD640–0xD67E are ignored: no load strobe, `hvMode` stays set, and the shadow bytes are unchanged.
- R8: In user mode, writes to the shadow window are ignored, and reads of it return 0x00.
- R9: Writes just outside the trap window (0xD63F, 0xD680) do not trap.
- R10: After reset, `hvMode`, `pcLoad`, `mapLoad` and `regsLoad` are low.
- R11: Each load strobe lasts exactly one cycle after an isolated entry or exit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | IO write strobe from the CPU |
| ioAddr | input | 16 | IO address, used for both writes and reads |
| ioWrData | input | 8 | IO write data |
| ioRdData | output | 8 | Shadow byte read data (combinational) |
| cpuA | input | 8 | Live accumulator |
| cpuX | input | 8 | Live X register |
| cpuY | input | 8 | Live Y register |
| cpuZ | input | 8 | Live Z register |
| cpuFlags | input | 8 | Live status flags (bit 0 carry) |
| cpuSp | input | 16 | Live stack pointer |
| cpuBp | input | 8 | Live base page register |
| cpuPc | input | 16 | Address of the instruction after the current store |
| cpuMap | input | 32 | Live memory mapping state |
| hvMode | output | 1 | High while in hypervisor mode |
| pcLoad | output | 1 | One-cycle request to load the PC |
| pcLoadValue | output | 16 | PC value to load |
| mapLoad | output | 1 | One-cycle request to load the memory mapping |
| mapLoadValue | output | 32 | Mapping value to load |
| regsLoad | output | 1 | One-cycle request to restore the CPU registers |
| restA | output | 8 | Restored accumulator |
| restX | output | 8 | Restored X |
| restY | output | 8 | Restored Y |
| restZ | output | 8 | Restored Z |
| restFlags | output | 8 | Restored flags |
| restSp | output | 16 | Restored stack pointer |
| restBp | output | 8 | Restored base page |

## Verification
On every cycle the assertions check the mode transitions: a user trap write sets the mode, an exit write clears it, and other trap addresses leave it set in hypervisor mode. They also check that a register restore happens only together with PC and map loads and only when leaving, that a restore strobe never repeats, that the accumulator is captured on entry, and that user-mode reads of the shadow window are zero. The bench scenarios cover the things a per-cycle property cannot show well: the vector value for each slot, that the data byte has no effect, the full shadow byte layout, restoring values the hypervisor edited, and the boundary addresses around both windows.

// File: rtl/hyp_trap_pkg.sv
package hyp_trap_pkg;

  localparam logic [15:0] TRAP_BASE    = 16'hD640;
  localparam int          TRAP_COUNT   = 64;
  localparam int          SLOT_BYTES   = 4;
  localparam logic [15:0] ENTRY_BASE   = 16'h8000;
  localparam logic [15:0] SHADOW_BASE  = 16'hD600;
  localparam int          SHADOW_BYTES = 14;
  localparam logic [31:0] HV_MAP       = 32'h0080_0000;

  localparam int TRAP_IDX_W = $clog2(TRAP_COUNT);
  localparam int SH_IDX_W   = $clog2(SHADOW_BYTES);

  // Shadow byte positions
  localparam int SH_A     = 0;
  localparam int SH_X     = 1;
  localparam int SH_Y     = 2;
  localparam int SH_Z     = 3;
  localparam int SH_FLAGS = 4;
  localparam int SH_SPL   = 5;
  localparam int SH_SPH   = 6;
  localparam int SH_BP    = 7;
  localparam int SH_PCL   = 8;
  localparam int SH_PCH   = 9;
  localparam int SH_MAP0  = 10;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  enter;
    logic                  leave;
    logic                  shadowWr;
    logic                  shadowHit;
    logic [TRAP_IDX_W-1:0] slot;
    logic [SH_IDX_W-1:0]   shIdx;
  } trap_ctl_t;

endpackage

// File: rtl/hyp_trap_ctl.sv
module hyp_trap_ctl
  import hyp_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWrEn,
  input  logic [15:0] ioAddr,
  output logic        hvMode,
  output trap_ctl_t   ctl
);

  localparam logic [15:0] TrapLast   = TRAP_BASE + 16'(TRAP_COUNT - 1);
  localparam logic [15:0] ShadowLast = SHADOW_BASE + 16'(SHADOW_BYTES - 1);

  logic inTrap;
  logic inShadow;
  logic isExit;

  assign inTrap   = (ioAddr >= TRAP_BASE) && (ioAddr <= TrapLast);
  assign inShadow = (ioAddr >= SHADOW_BASE) && (ioAddr <= ShadowLast);
  assign isExit   = (ioAddr == TrapLast);

  always_comb begin
    ctl.enter     = ioWrEn && !hvMode && inTrap;
    ctl.leave     = ioWrEn && hvMode && isExit;
    ctl.shadowWr  = ioWrEn && hvMode && inShadow;
    ctl.shadowHit = hvMode && inShadow;
    ctl.slot      = ioAddr[TRAP_IDX_W-1:0] - TRAP_BASE[TRAP_IDX_W-1:0];
    ctl.shIdx     = ioAddr[SH_IDX_W-1:0] - SHADOW_BASE[SH_IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hvMode <= 1'b0;
    end else if (ctl.enter) begin
      hvMode <= 1'b1;
    end else if (ctl.leave) begin
      hvMode <= 1'b0;
    end
  end

  // R1: user trap write enters hypervisor mode
  a_r1_enter_sets_mode: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && !hvMode && inTrap) |=> hvMode);

  // R5: exit write returns to user mode
  a_r5_exit_clears_mode: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && hvMode && isExit) |=> !hvMode);

  // R7: other trap addresses in hypervisor mode keep the mode
  a_r7_hv_trap_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && hvMode && inTrap && !isExit) |=> hvMode);

endmodule

// File: rtl/hyp_trap_dp.sv
module hyp_trap_dp
  import hyp_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  trap_ctl_t   ctl,
  input  logic        hvMode,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  input  logic [7:0]  cpuA,
  input  logic [7:0]  cpuX,
  input  logic [7:0]  cpuY,
  input  logic [7:0]  cpuZ,
  input  logic [7:0]  cpuFlags,
  input  logic [15:0] cpuSp,
  input  logic [7:0]  cpuBp,
  input  logic [15:0] cpuPc,
  input  logic [31:0] cpuMap,
  output logic        pcLoad,
  output logic [15:0] pcLoadValue,
  output logic        mapLoad,
  output logic [31:0] mapLoadValue,
  output logic        regsLoad,
  output logic [7:0]  restA,
  output logic [7:0]  restX,
  output logic [7:0]  restY,
  output logic [7:0]  restZ,
  output logic [7:0]  restFlags,
  output logic [15:0] restSp,
  output logic [7:0]  restBp
);

  logic [7:0] liveBytes [SHADOW_BYTES];
  logic [7:0] shadow    [SHADOW_BYTES];

  always_comb begin
    liveBytes[SH_A]     = cpuA;
    liveBytes[SH_X]     = cpuX;
    liveBytes[SH_Y]     = cpuY;
    liveBytes[SH_Z]     = cpuZ;
    liveBytes[SH_FLAGS] = cpuFlags;
    liveBytes[SH_SPL]   = cpuSp[7:0];
    liveBytes[SH_SPH]   = cpuSp[15:8];
    liveBytes[SH_BP]    = cpuBp;
    liveBytes[SH_PCL]   = cpuPc[7:0];
    liveBytes[SH_PCH]   = cpuPc[15:8];
    for (int k = 0; k < 4; k++) begin
      liveBytes[SH_MAP0+k] = cpuMap[8*k +: 8];
    end
  end

  // One register per shadow byte: capture on entry, edit by hypervisor
  for (genvar i = 0; i < SHADOW_BYTES; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadow[i] <= 8'h00;
      end else if (ctl.enter) begin
        shadow[i] <= liveBytes[i];
      end else if (ctl.shadowWr && (ctl.shIdx == SH_IDX_W'(i))) begin
        shadow[i] <= ioWrData;
      end
    end
  end

  assign ioRdData = ctl.shadowHit ? shadow[ctl.shIdx] : 8'h00;

  logic [15:0] entryPc;
  logic [15:0] savedPc;
  logic [31:0] savedMap;

  assign entryPc  = ENTRY_BASE + 16'(32'(ctl.slot) * SLOT_BYTES);
  assign savedPc  = {shadow[SH_PCH], shadow[SH_PCL]};
  assign savedMap = {shadow[SH_MAP0+3], shadow[SH_MAP0+2],
                     shadow[SH_MAP0+1], shadow[SH_MAP0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcLoad       <= 1'b0;
      mapLoad      <= 1'b0;
      regsLoad     <= 1'b0;
      pcLoadValue  <= 16'h0000;
      mapLoadValue <= 32'h0;
      restA        <= 8'h00;
      restX        <= 8'h00;
      restY        <= 8'h00;
      restZ        <= 8'h00;
      restFlags    <= 8'h00;
      restSp       <= 16'h0000;
      restBp       <= 8'h00;
    end else begin
      pcLoad   <= ctl.enter || ctl.leave;
      mapLoad  <= ctl.enter || ctl.leave;
      regsLoad <= ctl.leave;
      if (ctl.enter) begin
        pcLoadValue  <= entryPc;
        mapLoadValue <= HV_MAP;
      end else if (ctl.leave) begin
        pcLoadValue  <= savedPc;
        mapLoadValue <= savedMap;
        restA        <= shadow[SH_A];
        restX        <= shadow[SH_X];
        restY        <= shadow[SH_Y];
        restZ        <= shadow[SH_Z];
        restFlags    <= shadow[SH_FLAGS];
        restSp       <= {shadow[SH_SPH], shadow[SH_SPL]};
        restBp       <= shadow[SH_BP];
      end
    end
  end

  // R3: accumulator captured into its shadow byte on entry
  a_r3_capture_a: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enter |=> (shadow[SH_A] == $past(cpuA)));

  // R5: a register restore always comes with PC and map loads
  a_r5_restore_bundle: assert property (@(posedge clk) disable iff (!rstN)
    regsLoad |-> (pcLoad && mapLoad));

  // R4: registers are never restored while staying in hypervisor mode
  a_r4_no_restore_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    regsLoad |-> !hvMode);

  // R11: restore strobe is a single-cycle pulse
  a_r11_restore_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regsLoad |=> !regsLoad);

endmodule

// File: rtl/hyp_trap_ctrl.sv
module hyp_trap_ctrl
  import hyp_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWrEn,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  input  logic [7:0]  cpuA,
  input  logic [7:0]  cpuX,
  input  logic [7:0]  cpuY,
  input  logic [7:0]  cpuZ,
  input  logic [7:0]  cpuFlags,
  input  logic [15:0] cpuSp,
  input  logic [7:0]  cpuBp,
  input  logic [15:0] cpuPc,
  input  logic [31:0] cpuMap,
  output logic        hvMode,
  output logic        pcLoad,
  output logic [15:0] pcLoadValue,
  output logic        mapLoad,
  output logic [31:0] mapLoadValue,
  output logic        regsLoad,
  output logic [7:0]  restA,
  output logic [7:0]  restX,
  output logic [7:0]  restY,
  output logic [7:0]  restZ,
  output logic [7:0]  restFlags,
  output logic [15:0] restSp,
  output logic [7:0]  restBp
);

  trap_ctl_t ctl;

  hyp_trap_ctl i_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .ioWrEn (ioWrEn),
    .ioAddr (ioAddr),
    .hvMode (hvMode),
    .ctl    (ctl)
  );

  hyp_trap_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .hvMode       (hvMode),
    .ioWrData     (ioWrData),
    .ioRdData     (ioRdData),
    .cpuA         (cpuA),
    .cpuX         (cpuX),
    .cpuY         (cpuY),
    .cpuZ         (cpuZ),
    .cpuFlags     (cpuFlags),
    .cpuSp        (cpuSp),
    .cpuBp        (cpuBp),
    .cpuPc        (cpuPc),
    .cpuMap       (cpuMap),
    .pcLoad       (pcLoad),
    .pcLoadValue  (pcLoadValue),
    .mapLoad      (mapLoad),
    .mapLoadValue (mapLoadValue),
    .regsLoad     (regsLoad),
    .restA        (restA),
    .restX        (restX),
    .restY        (restY),
    .restZ        (restZ),
    .restFlags    (restFlags),
    .restSp       (restSp),
    .restBp       (restBp)
  );

  // R8: user mode never sees shadow contents
  a_r8_user_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hvMode |-> (ioRdData == 8'h00));

endmodule

// File: tb/test_hyp_trap_ctrl.sv
`timescale 1ns/1ps
module test_hyp_trap_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ioWrEn;
  logic [15:0] ioAddr;
  logic [7:0]  ioWrData;
  logic [7:0]  ioRdData;
  logic [7:0]  cpuA, cpuX, cpuY, cpuZ, cpuFlags, cpuBp;
  logic [15:0] cpuSp, cpuPc;
  logic [31:0] cpuMap;
  logic        hvMode, pcLoad, mapLoad, regsLoad;
  logic [15:0] pcLoadValue, restSp;
  logic [31:0] mapLoadValue;
  logic [7:0]  restA, restX, restY, restZ, restFlags, restBp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hyp_trap_ctrl i_hyp_trap_ctrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData),
    .cpuA(cpuA), .cpuX(cpuX), .cpuY(cpuY), .cpuZ(cpuZ),
    .cpuFlags(cpuFlags), .cpuSp(cpuSp), .cpuBp(cpuBp), .cpuPc(cpuPc),
    .cpuMap(cpuMap), .hvMode(hvMode), .pcLoad(pcLoad),
    .pcLoadValue(pcLoadValue), .mapLoad(mapLoad), .mapLoadValue(mapLoadValue),
    .regsLoad(regsLoad), .restA(restA), .restX(restX), .restY(restY),
    .restZ(restZ), .restFlags(restFlags), .restSp(restSp), .restBp(restBp)
  );

  // {trap address, data byte, expected entry PC}
  localparam logic [39:0] VECS [6] = '{
    {16'hD640, 8'h00, 16'h8000},
    {16'hD641, 8'hFF, 16'h8004},
    {16'hD650, 8'h3C, 16'h8040},
    {16'hD66A, 8'hA5, 16'h80A8},
    {16'hD67E, 8'h01, 16'h80F8},
    {16'hD67F, 8'h80, 16'h80FC}
  };

  localparam logic [31:0] HvMapExp = 32'h0080_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrIo(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0; ioAddr = 16'h0000; ioWrData = 8'h00;
  endtask

  task automatic rdIo(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a;
    #1 d = ioRdData;
    ioAddr = 16'h0000;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; ioWrEn = 1'b0; ioAddr = 16'h0; ioWrData = 8'h0;
    cpuA = 0; cpuX = 0; cpuY = 0; cpuZ = 0; cpuFlags = 0; cpuBp = 0;
    cpuSp = 0; cpuPc = 0; cpuMap = 0;
    repeat (3) @(negedge clk);
    chk("R10 hvMode", hvMode, 0);
    chk("R10 pcLoad", pcLoad, 0);
    chk("R10 mapLoad", mapLoad, 0);
    chk("R10 regsLoad", regsLoad, 0);
    rstN = 1'b1;

    // Table walk: entry vector per slot, capture, exit restore
    for (int i = 0; i < 6; i++) begin
      logic [7:0] savedA;
      logic [15:0] savedPc;
      savedA  = 8'h20 + 8'(i);
      savedPc = 16'h1230 + 16'(i);
      cpuA = savedA; cpuPc = savedPc; cpuMap = 32'h0000_0100 * i;
      cpuX = 8'h40 + 8'(i); cpuFlags = 8'h00;
      wrIo(VECS[i][39:24], VECS[i][23:16]);
      chk("R1 hvMode set", hvMode, 1);
      chk("R1 pcLoad", pcLoad, 1);
      chk("R1 entry vector", pcLoadValue, VECS[i][15:0]);
      chk("R4 mapLoad", mapLoad, 1);
      chk("R4 hv map", mapLoadValue, HvMapExp);
      chk("R4 no regsLoad", regsLoad, 0);
      rdIo(16'hD600, rd);
      chk("R2 shadow A not data", rd, savedA);
      chk("R11 pcLoad pulse", pcLoad, 0);
      cpuA = 8'hEE; cpuPc = 16'hFFFF; cpuX = 8'h99;
      wrIo(16'hD67F, 8'h00);
      chk("R5 hvMode cleared", hvMode, 0);
      chk("R5 regsLoad", regsLoad, 1);
      chk("R5 restA", restA, savedA);
      chk("R5 restX", restX, 8'h40 + 8'(i));
      chk("R5 saved pc", pcLoadValue, savedPc);
      chk("R5 saved map", mapLoadValue, 32'h0000_0100 * i);
      @(negedge clk);
      chk("R11 regsLoad pulse", regsLoad, 0);
    end

    // R3 layout and R6 edit-then-restore
    cpuA = 8'h11; cpuX = 8'h22; cpuY = 8'h33; cpuZ = 8'h44; cpuFlags = 8'h80;
    cpuSp = 16'hA1B2; cpuBp = 8'h5D; cpuPc = 16'hC3D4; cpuMap = 32'h1234_5678;
    wrIo(16'hD640, 8'h77);
    rdIo(16'hD600, rd); chk("R3 A", rd, 8'h11);
    rdIo(16'hD601, rd); chk("R3 X", rd, 8'h22);
    rdIo(16'hD602, rd); chk("R3 Y", rd, 8'h33);
    rdIo(16'hD603, rd); chk("R3 Z", rd, 8'h44);
    rdIo(16'hD604, rd); chk("R3 flags", rd, 8'h80);
    rdIo(16'hD605, rd); chk("R3 sp lo", rd, 8'hB2);
    rdIo(16'hD606, rd); chk("R3 sp hi", rd, 8'hA1);
    rdIo(16'hD607, rd); chk("R3 bp", rd, 8'h5D);
    rdIo(16'hD608, rd); chk("R3 pc lo", rd, 8'hD4);
    rdIo(16'hD609, rd); chk("R3 pc hi", rd, 8'hC3);
    rdIo(16'hD60A, rd); chk("R3 map0", rd, 8'h78);
    rdIo(16'hD60D, rd); chk("R3 map3", rd, 8'h12);
    // R7: other trap addresses ignored in hypervisor mode
    wrIo(16'hD645, 8'h00);
    chk("R7 no pcLoad", pcLoad, 0);
    chk("R7 hvMode held", hvMode, 1);
    wrIo(16'hD67E, 8'h00);
    chk("R7 D67E no pcLoad", pcLoad, 0);
    rdIo(16'hD608, rd); chk("R7 shadow pc unchanged", rd, 8'hD4);
    rdIo(16'hD600, rd); chk("R7 shadow A unchanged", rd, 8'h11);
    // R6: hypervisor edits shadows
    wrIo(16'hD604, 8'h81);
    wrIo(16'hD600, 8'h5A);
    wrIo(16'hD609, 8'h90);
    rdIo(16'hD604, rd); chk("R6 readback flags", rd, 8'h81);
    wrIo(16'hD67F, 8'h00);
    chk("R6 restFlags carry", restFlags, 8'h81);
    chk("R6 restA edited", restA, 8'h5A);
    chk("R6 pc edited", pcLoadValue, 16'h90D4);
    chk("R5 restSp", restSp, 16'hA1B2);
    chk("R5 restBp", restBp, 8'h5D);
    chk("R5 restY", restY, 8'h33);
    chk("R5 restZ", restZ, 8'h44);

    // R8: user mode shadow window
    wrIo(16'hD600, 8'hAA);
    chk("R8 no trap on shadow write", hvMode, 0);
    chk("R8 no pcLoad", pcLoad, 0);
    rdIo(16'hD600, rd); chk("R8 user read zero", rd, 8'h00);
    rdIo(16'hD609, rd); chk("R8 user read pc zero", rd, 8'h00);

    // R9: boundaries
    wrIo(16'hD63F, 8'h00);
    chk("R9 D63F no trap", hvMode, 0);
    chk("R9 D63F no pcLoad", pcLoad, 0);
    wrIo(16'hD680, 8'h00);
    chk("R9 D680 no trap", hvMode, 0);
    chk("R9 D680 no pcLoad", pcLoad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule